// File: doc/BRIEF.md
# SIMT Reconvergence Stack

This block keeps the divergence state of one warp for immediate post-dominator reconvergence. Each stack slot records a program counter, the reconvergence PC at which its lanes rejoin, the mask of lanes that run at that PC, and a call-depth flag. A launch empties the stack and puts the start PC and the initial lane mask in slot 0. After each instruction the core issues an update. The update carries the lanes that have finished, the next PC of every lane, and the reconvergence PC of the branch just executed. The block then replaces the top slot, or splits it into a reconvergence slot followed by one slot per distinct next-PC group.

The update is processed one lane group per clock by a two-state sequencer. State ST_IDLE holds the stack steady. The transition ST_IDLE to ST_GROUP is taken when an update is requested and no launch is present. ST_GROUP stays in ST_GROUP while ungrouped lanes remain. It takes the transition ST_GROUP to ST_IDLE once the last group is handled, or at once on a launch. A group whose PC equals the old top's reconvergence PC is discarded as it is found, so popping needs no separate step. The old top slot itself becomes the reconvergence slot. The top slot's PC, reconvergence PC, mask, call-depth flag and index are always visible at the outputs.

Top module: `simt_reconv_stack`

## Requirements
- R1: After reset the top index is 0, the top PC and reconvergence PC are all ones, the top mask is 0, the call-depth flag is 0, and busy and overflow are low.
- R2: A launch empties every slot and loads slot 0 with the launch PC, the launch mask, call-depth flag 1 and an all-ones reconvergence PC. It also sets the top index to 0 and clears overflow. A launch aborts any update in progress.
- R3: An update request is accepted only while busy is low. Busy then stays high for one clock per lane group examined, with a minimum of one clock. Requests made while busy have no effect on the result.
- R4: Lanes set in the done mask leave the active set. When only one group survives, it overwrites the top slot's PC and mask, keeps the old reconvergence PC and call-depth flag, and the top index does not change.
- R5: Lanes are grouped from the highest lane index down. The group led by the highest remaining lane is placed in the lowest new slot, so the group holding the lowest lanes ends on top.
- R6: The first kept group that leaves other lanes ungrouped marks divergence. If the branch reconvergence PC differs from the top's, only the old top slot's PC is rewritten to the branch reconvergence PC and the groups are placed above it. Every group placed after divergence carries the branch reconvergence PC and call-depth flag 0.
- R7: A group whose next PC equals the old top's reconvergence PC is discarded, and the top index ends one below the last slot written. When every group is discarded, the top index drops by one.
- R8: After divergence, a group whose next PC equals the branch reconvergence PC is discarded.
- R9: When the branch reconvergence PC equals the old top's, no reconvergence slot is made and the groups are written starting at the old top slot.
- R10: If an update at slot 0 discards every lane, the top index stays 0 and the top mask becomes 0, which marks the warp finished.
- R11: A slot write beyond DEPTH-1 is discarded and sets overflow. Overflow stays set until reset or launch. DEPTH defaults to twice LANES.
- R12: While idle with no request and no launch, all top outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| launch_i | input | 1 | Empty the stack and load slot 0 |
| launch_pc_i | input | PC_W | Start PC for slot 0 |
| launch_mask_i | input | LANES | Initial active lanes |
| upd_i | input | 1 | Update request, accepted while not busy |
| done_mask_i | input | LANES | Lanes that have finished |
| next_pc_i | input | LANES*PC_W | Next PC per lane, lane i in bits [i*PC_W +: PC_W] |
| br_rpc_i | input | PC_W | Reconvergence PC of the executed branch |
| top_pc_o | output | PC_W | PC of the top slot |
| top_rpc_o | output | PC_W | Reconvergence PC of the top slot |
| top_mask_o | output | LANES | Active lanes of the top slot |
| top_cd_o | output | 1 | Call-depth flag of the top slot |
| top_idx_o | output | clog2(DEPTH) | Index of the top slot |
| busy_o | output | 1 | Update in progress |
| overflow_o | output | 1 | Sticky slot-overflow flag |

## Verification
The assertions check several things on every cycle. Overflow stays set and only rises during an update. An accepted request raises busy. A launch leaves slot 0 exactly as loaded. A non-zero top index never shows an empty mask. The idle stack does not drift. Only the bench scenarios can show that the grouping order is correct, that the discards on the old and new reconvergence PCs happen, and that the reconvergence slot is rewritten or skipped as required. They also show the busy length per group and the finished-warp case. A reduced depth in the bench makes overflow reachable.

// File: rtl/simt_reconv_pkg.sv
package simt_reconv_pkg;
    typedef enum logic [0:0] {
        ST_IDLE,
        ST_GROUP
    } seq_state_e;
endpackage

// File: rtl/simt_lane_grouper.sv
module simt_lane_grouper #(
    parameter int LANES = 4,
    parameter int PC_W  = 8
) (
    input  logic [LANES-1:0]      rem_i,
    input  logic [LANES*PC_W-1:0] npc_i,
    output logic [PC_W-1:0]       grp_pc_o,
    output logic [LANES-1:0]      grp_mask_o
);
    logic [PC_W-1:0] lane_pc [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_pc[g]    = npc_i[g*PC_W +: PC_W];
        assign grp_mask_o[g] = rem_i[g] && (lane_pc[g] == grp_pc_o);
    end

    // leader is the highest remaining lane
    always_comb begin
        logic found;
        found    = 1'b0;
        grp_pc_o = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (rem_i[i] && !found) begin
                grp_pc_o = lane_pc[i];
                found    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/simt_stack_store.sv
module simt_stack_store #(
    parameter int LANES = 4,
    parameter int PC_W  = 8,
    parameter int DEPTH = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_i,
    input  logic [PC_W-1:0]  init_pc_i,
    input  logic [LANES-1:0] init_mask_i,
    input  logic             rw_we_i,
    input  logic [IDX_W-1:0] rw_idx_i,
    input  logic [PC_W-1:0]  rw_pc_i,
    input  logic             ew_we_i,
    input  logic [IDX_W-1:0] ew_idx_i,
    input  logic [PC_W-1:0]  ew_pc_i,
    input  logic [PC_W-1:0]  ew_rpc_i,
    input  logic [LANES-1:0] ew_mask_i,
    input  logic             ew_cd_clr_i,
    input  logic             kill_i,
    input  logic [IDX_W-1:0] rd_idx_i,
    output logic [PC_W-1:0]  rd_pc_o,
    output logic [PC_W-1:0]  rd_rpc_o,
    output logic [LANES-1:0] rd_mask_o,
    output logic             rd_cd_o
);
    logic [PC_W-1:0]  pc_q   [DEPTH];
    logic [PC_W-1:0]  rpc_q  [DEPTH];
    logic [LANES-1:0] mask_q [DEPTH];
    logic             cd_q   [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                pc_q[i]   <= '1;
                rpc_q[i]  <= '1;
                mask_q[i] <= '0;
                cd_q[i]   <= 1'b0;
            end
        end else if (init_i) begin
            for (int i = 0; i < DEPTH; i++) begin
                pc_q[i]   <= '1;
                rpc_q[i]  <= '1;
                mask_q[i] <= '0;
                cd_q[i]   <= 1'b0;
            end
            pc_q[0]   <= init_pc_i;
            mask_q[0] <= init_mask_i;
            cd_q[0]   <= 1'b1;
        end else begin
            if (rw_we_i) pc_q[rw_idx_i] <= rw_pc_i;
            if (ew_we_i) begin
                pc_q[ew_idx_i]   <= ew_pc_i;
                rpc_q[ew_idx_i]  <= ew_rpc_i;
                mask_q[ew_idx_i] <= ew_mask_i;
                if (ew_cd_clr_i) cd_q[ew_idx_i] <= 1'b0;
            end
            if (kill_i) mask_q[0] <= '0;
        end
    end

    assign rd_pc_o   = pc_q[rd_idx_i];
    assign rd_rpc_o  = rpc_q[rd_idx_i];
    assign rd_mask_o = mask_q[rd_idx_i];
    assign rd_cd_o   = cd_q[rd_idx_i];
endmodule

// File: rtl/simt_reconv_stack.sv
module simt_reconv_stack
    import simt_reconv_pkg::*;
#(
    parameter int LANES = 4,
    parameter int PC_W  = 8,
    parameter int DEPTH = 2 * LANES
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       launch_i,
    input  logic [PC_W-1:0]            launch_pc_i,
    input  logic [LANES-1:0]           launch_mask_i,
    input  logic                       upd_i,
    input  logic [LANES-1:0]           done_mask_i,
    input  logic [LANES*PC_W-1:0]      next_pc_i,
    input  logic [PC_W-1:0]            br_rpc_i,
    output logic [PC_W-1:0]            top_pc_o,
    output logic [PC_W-1:0]            top_rpc_o,
    output logic [LANES-1:0]           top_mask_o,
    output logic                       top_cd_o,
    output logic [$clog2(DEPTH)-1:0]   top_idx_o,
    output logic                       busy_o,
    output logic                       overflow_o
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int PTR_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_LIM = PTR_W'(DEPTH);

    seq_state_e state_q, state_d;

    logic [LANES-1:0]      rem_q;
    logic [LANES*PC_W-1:0] npc_q;
    logic [PC_W-1:0]       br_q, old_q;
    logic [PTR_W-1:0]      ptr_q;
    logic                  div_q;
    logic [IDX_W-1:0]      top_q;
    logic                  ovf_q;

    logic [PC_W-1:0]  grp_pc;
    logic [LANES-1:0] grp_mask, rest;
    logic             grp_valid, drop_old, drop_new, start_div, div_n;
    logic             recon, push, finish, in_grp, ovf_set;
    logic [PTR_W-1:0] ptr_a, ptr_b;
    logic             rw_we, ew_we, kill;
    logic [IDX_W-1:0] top_n;

    simt_lane_grouper #(.LANES(LANES), .PC_W(PC_W)) grouper_i (
        .rem_i      (rem_q),
        .npc_i      (npc_q),
        .grp_pc_o   (grp_pc),
        .grp_mask_o (grp_mask)
    );

    // group decode for the current ST_GROUP clock
    always_comb begin
        in_grp    = (state_q == ST_GROUP) && !launch_i;
        grp_valid = (rem_q != '0);
        rest      = rem_q & ~grp_mask;
        drop_old  = (grp_pc == old_q);
        start_div = grp_valid && !drop_old && (rest != '0) && !div_q;
        div_n     = div_q || start_div;
        recon     = start_div && (br_q != old_q);
        ptr_a     = (recon && ptr_q < PTR_LIM) ? ptr_q + 1'b1 : ptr_q;
        drop_new  = div_n && (grp_pc == br_q);
        push      = grp_valid && !drop_old && !drop_new;
        ptr_b     = (push && ptr_a < PTR_LIM) ? ptr_a + 1'b1 : ptr_a;
        ovf_set   = (recon && ptr_q >= PTR_LIM) || (push && ptr_a >= PTR_LIM);
        rw_we     = in_grp && recon && (ptr_q < PTR_LIM);
        ew_we     = in_grp && push && (ptr_a < PTR_LIM);
        finish    = !grp_valid || (rest == '0);
        kill      = in_grp && finish && (ptr_b == '0);
        top_n     = (ptr_b == '0) ? '0 : IDX_W'(ptr_b - 1'b1);
    end

    simt_stack_store #(.LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) store_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .init_i      (launch_i),
        .init_pc_i   (launch_pc_i),
        .init_mask_i (launch_mask_i),
        .rw_we_i     (rw_we),
        .rw_idx_i    (IDX_W'(ptr_q)),
        .rw_pc_i     (br_q),
        .ew_we_i     (ew_we),
        .ew_idx_i    (IDX_W'(ptr_a)),
        .ew_pc_i     (grp_pc),
        .ew_rpc_i    (div_n ? br_q : old_q),
        .ew_mask_i   (grp_mask),
        .ew_cd_clr_i (div_n),
        .kill_i      (kill),
        .rd_idx_i    (top_q),
        .rd_pc_o     (top_pc_o),
        .rd_rpc_o    (top_rpc_o),
        .rd_mask_o   (top_mask_o),
        .rd_cd_o     (top_cd_o)
    );

    // next-state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (upd_i && !launch_i) state_d = ST_GROUP;
            ST_GROUP: if (launch_i || finish) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // sequencing registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
            npc_q <= '0;
            br_q  <= '0;
            old_q <= '0;
            ptr_q <= '0;
            div_q <= 1'b0;
            top_q <= '0;
            ovf_q <= 1'b0;
        end else if (launch_i) begin
            rem_q <= '0;
            div_q <= 1'b0;
            top_q <= '0;
            ovf_q <= 1'b0;
        end else if (state_q == ST_IDLE) begin
            if (upd_i) begin
                rem_q <= top_mask_o & ~done_mask_i;
                npc_q <= next_pc_i;
                br_q  <= br_rpc_i;
                old_q <= top_rpc_o;
                ptr_q <= PTR_W'(top_q);
                div_q <= 1'b0;
            end
        end else begin
            rem_q <= rest;
            div_q <= div_n;
            ptr_q <= ptr_b;
            if (ovf_set) ovf_q <= 1'b1;
            if (finish)  top_q <= top_n;
        end
    end

    // outputs
    always_comb begin
        busy_o     = (state_q == ST_GROUP);
        overflow_o = ovf_q;
        top_idx_o  = top_q;
    end
endmodule

// File: rtl/simt_reconv_chk.sv
module simt_reconv_chk #(
    parameter int LANES = 4,
    parameter int PC_W  = 8,
    parameter int DEPTH = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     launch_i,
    input logic [PC_W-1:0]          launch_pc_i,
    input logic [LANES-1:0]         launch_mask_i,
    input logic                     upd_i,
    input logic [PC_W-1:0]          top_pc_o,
    input logic [PC_W-1:0]          top_rpc_o,
    input logic [LANES-1:0]         top_mask_o,
    input logic                     top_cd_o,
    input logic [$clog2(DEPTH)-1:0] top_idx_o,
    input logic                     busy_o,
    input logic                     overflow_o
);
    // R11
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_o && !launch_i |=> overflow_o);

    // R11
    ovf_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow_o) |-> $past(busy_o));

    // R3
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o && upd_i && !launch_i |=> busy_o);

    // R2
    launch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        launch_i |=> top_idx_o == '0 && top_pc_o == $past(launch_pc_i)
                     && top_mask_o == $past(launch_mask_i) && top_cd_o
                     && top_rpc_o == '1 && !busy_o && !overflow_o);

    // R10
    live_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o && top_idx_o != '0 |-> top_mask_o != '0);

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o && !upd_i && !launch_i |=> $stable(top_pc_o) && $stable(top_idx_o)
                                           && $stable(top_mask_o) && $stable(top_rpc_o));
endmodule

bind simt_reconv_stack simt_reconv_chk #(.LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .launch_i      (launch_i),
    .launch_pc_i   (launch_pc_i),
    .launch_mask_i (launch_mask_i),
    .upd_i         (upd_i),
    .top_pc_o      (top_pc_o),
    .top_rpc_o     (top_rpc_o),
    .top_mask_o    (top_mask_o),
    .top_cd_o      (top_cd_o),
    .top_idx_o     (top_idx_o),
    .busy_o        (busy_o),
    .overflow_o    (overflow_o)
);

// File: tb/simt_reconv_stack_tb_top.sv
module simt_reconv_stack_tb_top;
    localparam int LANES = 4;
    localparam int PC_W  = 8;
    localparam int DEPTH = 4;   // reduced so overflow can be reached

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic launch = 1'b0;
    logic [PC_W-1:0] launch_pc = '0;
    logic [LANES-1:0] launch_mask = '0;
    logic upd = 1'b0;
    logic [LANES-1:0] done_mask = '0;
    logic [LANES*PC_W-1:0] next_pc = '0;
    logic [PC_W-1:0] br_rpc = '0;
    logic [PC_W-1:0] top_pc_o, top_rpc_o;
    logic [LANES-1:0] top_mask_o;
    logic top_cd_o, busy_o, overflow_o;
    logic [$clog2(DEPTH)-1:0] top_idx_o;

    int checks = 0;
    int bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    simt_reconv_stack #(.LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .launch_i(launch), .launch_pc_i(launch_pc),
        .launch_mask_i(launch_mask), .upd_i(upd), .done_mask_i(done_mask),
        .next_pc_i(next_pc), .br_rpc_i(br_rpc), .top_pc_o(top_pc_o),
        .top_rpc_o(top_rpc_o), .top_mask_o(top_mask_o), .top_cd_o(top_cd_o),
        .top_idx_o(top_idx_o), .busy_o(busy_o), .overflow_o(overflow_o)
    );

    function automatic logic [LANES*PC_W-1:0] pk(input logic [7:0] l3, l2, l1, l0);
        return {l3, l2, l1, l0};
    endfunction

    task automatic expect_top(input string req, input logic [7:0] pc, rpc,
                              input logic [3:0] m, input logic cd, input int idx);
        checks++;
        if (top_pc_o !== pc || top_rpc_o !== rpc || top_mask_o !== m ||
            top_cd_o !== cd || int'(top_idx_o) != idx) begin
            bad++;
            $display("FAIL %s: got pc=%h rpc=%h mask=%b cd=%b idx=%0d, expected pc=%h rpc=%h mask=%b cd=%b idx=%0d",
                     req, top_pc_o, top_rpc_o, top_mask_o, top_cd_o, top_idx_o, pc, rpc, m, cd, idx);
        end
    endtask

    task automatic expect_val(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: %s got %0d, expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_launch(input logic [7:0] pc, input logic [3:0] m);
        @(negedge clk);
        launch = 1'b1; launch_pc = pc; launch_mask = m;
        @(negedge clk);
        launch = 1'b0;
    endtask

    // poke: issue a second request with other PCs during the first busy clock
    task automatic do_upd(input logic [3:0] dm, input logic [LANES*PC_W-1:0] np,
                          input logic [7:0] r, input bit poke, output int cyc);
        @(negedge clk);
        done_mask = dm; next_pc = np; br_rpc = r; upd = 1'b1;
        @(negedge clk);
        upd = 1'b0;
        cyc = 0;
        while (busy_o && cyc < 50) begin
            cyc++;
            if (poke && cyc == 1) begin
                upd = 1'b1;
                next_pc = pk(8'hA1, 8'hA2, 8'hA3, 8'hA4);
            end else begin
                upd = 1'b0;
            end
            @(negedge clk);
        end
        upd = 1'b0;
    endtask

    task automatic t_reset();
        expect_top("R1 reset", 8'hFF, 8'hFF, 4'b0000, 1'b0, 0);
        expect_val("R1 reset", "busy", int'(busy_o), 0);
        expect_val("R1 reset", "overflow", int'(overflow_o), 0);
    endtask

    task automatic t_launch_uniform();
        int c;
        do_launch(8'h10, 4'b1111);
        expect_top("R2 launch", 8'h10, 8'hFF, 4'b1111, 1'b1, 0);
        do_upd(4'b0000, pk(8'h11, 8'h11, 8'h11, 8'h11), 8'h20, 0, c);
        expect_top("R4 uniform", 8'h11, 8'hFF, 4'b1111, 1'b1, 0);
        expect_val("R3 one group", "busy cycles", c, 1);
        do_upd(4'b0001, pk(8'h12, 8'h12, 8'h12, 8'h12), 8'h20, 0, c);
        expect_top("R4 done lane removed", 8'h12, 8'hFF, 4'b1110, 1'b1, 0);
    endtask

    task automatic t_diverge_pop();
        int c;
        do_upd(4'b0000, pk(8'h30, 8'h30, 8'h40, 8'h99), 8'h50, 1, c);
        expect_top("R5 R6 split order", 8'h40, 8'h50, 4'b0010, 1'b0, 2);
        expect_val("R3 two groups, poke ignored", "busy cycles", c, 2);
        do_upd(4'b0000, pk(8'h00, 8'h00, 8'h50, 8'h00), 8'h77, 0, c);
        expect_top("R7 pop to upper group", 8'h30, 8'h50, 4'b1100, 1'b0, 1);
        do_upd(4'b0000, pk(8'h50, 8'h50, 8'h00, 8'h00), 8'h77, 0, c);
        expect_top("R6 R7 reconvergence slot", 8'h50, 8'hFF, 4'b1110, 1'b1, 0);
    endtask

    task automatic t_drop_new();
        int c;
        do_upd(4'b0000, pk(8'h60, 8'h70, 8'h70, 8'h00), 8'h70, 0, c);
        expect_top("R8 drop on branch rpc", 8'h60, 8'h70, 4'b1000, 1'b0, 1);
        expect_val("R8 groups examined", "busy cycles", c, 2);
    endtask

    task automatic t_same_rpc_exit();
        int c;
        do_launch(8'h10, 4'b1111);
        do_upd(4'b0000, pk(8'h21, 8'h21, 8'h22, 8'h22), 8'hFF, 0, c);
        expect_top("R9 no reconvergence slot", 8'h22, 8'hFF, 4'b0011, 1'b0, 1);
        do_upd(4'b0011, pk(8'h00, 8'h00, 8'h00, 8'h00), 8'h00, 0, c);
        expect_top("R7 all done pops", 8'h21, 8'hFF, 4'b1100, 1'b0, 0);
        do_upd(4'b1100, pk(8'h00, 8'h00, 8'h00, 8'h00), 8'h00, 0, c);
        expect_top("R10 warp finished", 8'h21, 8'hFF, 4'b0000, 1'b0, 0);
    endtask

    task automatic t_overflow();
        int c;
        do_launch(8'h00, 4'b1111);
        do_upd(4'b0000, pk(8'h01, 8'h02, 8'h03, 8'h04), 8'h80, 0, c);
        expect_top("R11 write past depth dropped", 8'h03, 8'h80, 4'b0010, 1'b0, 3);
        expect_val("R11 overflow set", "overflow", int'(overflow_o), 1);
        expect_val("R3 four groups", "busy cycles", c, 4);
        do_upd(4'b0000, pk(8'h00, 8'h00, 8'h33, 8'h00), 8'h90, 0, c);
        expect_top("R4 update after overflow", 8'h33, 8'h80, 4'b0010, 1'b0, 3);
        expect_val("R11 overflow sticky", "overflow", int'(overflow_o), 1);
        repeat (3) @(negedge clk);
        expect_top("R12 idle hold", 8'h33, 8'h80, 4'b0010, 1'b0, 3);
        do_launch(8'h44, 4'b0101);
        expect_val("R2 R11 launch clears overflow", "overflow", int'(overflow_o), 0);
        expect_top("R2 relaunch", 8'h44, 8'hFF, 4'b0101, 1'b1, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_launch_uniform();
        t_diverge_pop();
        t_drop_new();
        t_same_rpc_exit();
        t_overflow();
        finished = 1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            bad++;
            $display("FAIL watchdog: run did not complete");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end
endmodule